// File: doc/BRIEF.md
# Dual-Context Parallel Port DMA Channel

This block is a single DMA channel that carries bytes between system memory and a byte-wide parallel peripheral. Software loads up to two transfer descriptors, context A and context B, through a 64-bit register port. It then marks each one valid. The engine runs the valid contexts in alternation. Software can refill the idle context while the other one is moving data, which gives a ping-pong stream without gaps in the bookkeeping.

Each descriptor holds a byte base address, a 12-bit byte length and a "last" flag. The channel moves one byte per memory handshake. In the memory-to-device direction it reads a byte and offers it to the device. In the device-to-memory direction it accepts a byte from the device and writes it to memory. When a context finishes, the channel raises that context's interrupt, drops its valid bit and turns to the other context. If the finished descriptor had its last flag set, the channel also sends a one-cycle terminal-count pulse to the device. A descriptor that would cross a 4 KiB page raises the memory-error interrupt instead and moves no data. So does an unaligned base in the device-to-memory direction.

The engine is a Moore state machine with these states:

| State | Role | Transitions |
|---|---|---|
| IDLE | Waits for work | To LOAD when the channel is enabled and the selected context is valid |
| LOAD | Checks the selected descriptor and latches its address, count and last flag | To FAULT on a bad descriptor; to DONE on a zero length; otherwise to FETCH (output direction) or CAPT (input direction) |
| FETCH | Memory read request | To PUSH on a grant |
| PUSH | Byte offered to the device | On acceptance: to DONE after the final byte, otherwise back to FETCH |
| CAPT | Ready to take a byte from the device | To STORE on device valid |
| STORE | Memory write request | On a grant: to DONE after the final byte, otherwise back to CAPT |
| DONE | Completion interrupt, terminal count if the last flag is set, clears the valid bit, toggles the context | To IDLE |
| FAULT | Memory-error interrupt, clears the valid bit, toggles the context | To IDLE |

While enable is low, every transition that waits on a handshake or starts work is held.

Top module: `pdma_pingpong`

## Requirements
- R1: Register addresses are as follows.
  - 0 is context A and 1 is context B. Each context word has the base in bits 31:0, the length in bits 43:32 and the last flag in bit 63; other bits read 0.
  - 2 is control: bit 0 is direction (1 = device to memory), bit 1 is enable, bit 2 is soft reset, bit 3 is the B valid bit and bit 4 is the A valid bit.
  - 3 is diagnostic (read only): bit 0 is the context in use (1 = B), bit 1 is active, and bits 13:2 are the bytes remaining.
  - After a hardware reset every register reads 0.
- R2: In the memory-to-device direction, the bytes read from memory at base, base+1, … are presented to the device in that order. Exactly "length" bytes are presented, and a memory request is held with a stable address until it is granted.
- R3: In the device-to-memory direction, each byte accepted from the device is written to memory in arrival order, at addresses base, base+1, …, for exactly "length" bytes.
- R4: After reset the engine starts on context A. Finishing a context pulses its own interrupt for one cycle (A or B), clears its valid bit and selects the other context. If that context is not valid, the engine stays idle with active = 0. At most one of the three interrupts is high in any cycle.
- R5: When the finishing context has its last flag set, the terminal-count output pulses high for exactly one cycle after its final byte is transferred. No pulse is sent when the flag is 0.
- R6: A descriptor whose base[11:0] + length exceeds 4096 moves no data. It pulses the memory-error interrupt, clears its valid bit and selects the other context. A transfer that ends exactly on the page boundary is allowed.
- R7: In the device-to-memory direction, a base with a nonzero value in bits 5:0 is treated as a memory error, as in R6. In the memory-to-device direction any byte alignment is accepted.
- R8: While enable is 0, no memory request, device valid or device ready is asserted. The byte counter, the current address and the context selection hold, and diagnostic active reads 0. Setting enable again resumes with the next byte not yet transferred.
- R9: While soft reset is 1, the channel clears both valid bits, the byte counter, the active flag and the context selection, and suppresses every interrupt. The context registers keep their contents.
- R10: A write to a context register is ignored while that context is valid and selected. Otherwise the write takes effect.
- R11: A zero-length context completes without a memory access. It still raises its interrupt and, if its last flag is set, the terminal-count pulse.
- R12: The control valid bits are set by writing 1. Writing 0 leaves them unchanged. Only completion, a fault or a reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_gnt |
| mem_gnt | input | 1 | Memory grant; completes the request in this cycle |
| dev_out_valid | output | 1 | Byte offered to the device |
| dev_out_data | output | 8 | Byte to the device |
| dev_out_ready | input | 1 | Device accepts the offered byte |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_data | input | 8 | Byte from the device |
| dev_in_ready | output | 1 | Channel accepts a device byte |
| dev_tc | output | 1 | Terminal-count pulse to the device |
| irq_ctx_a | output | 1 | Context A completion pulse |
| irq_ctx_b | output | 1 | Context B completion pulse |
| irq_mem_err | output | 1 | Memory-error pulse |

## Verification
The assertions assume the following about the memory port and the register interface:
- The memory port completes a request in the cycle that mem_gnt is high.
- Software changes the control register only through whole-word writes.
- A freeze, soft reset or enable change takes effect one cycle after the register write.

The stimulus keeps to these assumptions. The bench drives grant, device ready and device valid from a pseudo-random sequence at the falling edge. It writes registers only through a task that holds a single-cycle strobe, and it loads every descriptor before setting that descriptor's valid bit.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;
    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 12;
    localparam int BYTE_W   = 8;
    localparam int REG_W    = 64;
    localparam int PAGE_W   = 12;
    localparam int ALIGN_W  = 6;
    localparam int LEN_LSB  = 32;
    localparam int LAST_BIT = 63;
    localparam int GAP_W    = LAST_BIT - LEN_LSB - LEN_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_FETCH, ST_PUSH, ST_CAPT, ST_STORE, ST_DONE, ST_FAULT
    } eng_state_t;

    typedef enum logic [1:0] {
        RA_CTX_A = 2'd0, RA_CTX_B = 2'd1, RA_CTRL = 2'd2, RA_DIAG = 2'd3
    } reg_addr_t;

    typedef struct packed {
        logic              last;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
    } desc_t;
endpackage

// File: rtl/pdma_desc_chk.sv
`timescale 1ns/1ps
module pdma_desc_chk
    import pdma_pkg::*;
(
    input  desc_t desc,
    input  logic  dir_in,
    output logic  bad
);
    localparam logic [PAGE_W:0] PAGE_BYTES = (PAGE_W+1)'(1) << PAGE_W;

    logic [PAGE_W:0] end_off;
    logic            crosses;
    logic            misaligned;
    logic            unused_base;

    assign end_off     = {1'b0, desc.base[PAGE_W-1:0]} + (PAGE_W+1)'(desc.len);
    assign crosses     = end_off > PAGE_BYTES;
    assign misaligned  = dir_in && (desc.base[ALIGN_W-1:0] != '0);
    assign bad         = crosses || misaligned;
    assign unused_base = ^{desc.base[ADDR_W-1:PAGE_W], desc.last};
endmodule

// File: rtl/pdma_regs.sv
`timescale 1ns/1ps
module pdma_regs
    import pdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cur_ctx,
    input  logic [1:0]       done_clr,
    input  logic [LEN_W-1:0] cnt,
    input  logic             active,
    output desc_t            desc_a,
    output desc_t            desc_b,
    output logic             ctl_dir,
    output logic             ctl_en,
    output logic             ctl_srst,
    output logic [1:0]       ctx_valid
);
    localparam int DIAG_PAD = REG_W - LEN_W - 2;
    localparam int CTRL_PAD = REG_W - 5;

    logic       wr_a, wr_b, wr_ctl;
    logic [1:0] set_bits;
    logic       unused_wbits;

    function automatic desc_t unpack_desc(input logic [REG_W-1:0] w);
        desc_t d;
        d.base = w[ADDR_W-1:0];
        d.len  = w[LEN_LSB +: LEN_W];
        d.last = w[LAST_BIT];
        return d;
    endfunction

    function automatic logic [REG_W-1:0] pack_desc(input desc_t d);
        return {d.last, {GAP_W{1'b0}}, d.len, d.base};
    endfunction

    // a context in use and valid is write-protected
    assign wr_a   = reg_wr && (reg_addr == RA_CTX_A) && !(ctx_valid[0] && !cur_ctx);
    assign wr_b   = reg_wr && (reg_addr == RA_CTX_B) && !(ctx_valid[1] &&  cur_ctx);
    assign wr_ctl = reg_wr && (reg_addr == RA_CTRL);
    assign set_bits = wr_ctl ? {reg_wdata[3], reg_wdata[4]} : 2'b00;
    assign unused_wbits = ^{reg_wdata[LAST_BIT-1:LEN_LSB+LEN_W], reg_wdata[LEN_LSB-1:ADDR_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_a    <= '0;
            desc_b    <= '0;
            ctl_dir   <= 1'b0;
            ctl_en    <= 1'b0;
            ctl_srst  <= 1'b0;
            ctx_valid <= 2'b00;
        end else begin
            if (wr_a) desc_a <= unpack_desc(reg_wdata);
            if (wr_b) desc_b <= unpack_desc(reg_wdata);
            if (wr_ctl) begin
                ctl_dir  <= reg_wdata[0];
                ctl_en   <= reg_wdata[1];
                ctl_srst <= reg_wdata[2];
            end
            if (ctl_srst) ctx_valid <= 2'b00;
            else          ctx_valid <= (ctx_valid & ~done_clr) | set_bits;
        end
    end

    always_comb begin
        unique case (reg_addr_t'(reg_addr))
            RA_CTX_A: reg_rdata = pack_desc(desc_a);
            RA_CTX_B: reg_rdata = pack_desc(desc_b);
            RA_CTRL:  reg_rdata = {{CTRL_PAD{1'b0}}, ctx_valid[0], ctx_valid[1],
                                   ctl_srst, ctl_en, ctl_dir};
            RA_DIAG:  reg_rdata = {{DIAG_PAD{1'b0}}, cnt, active, cur_ctx};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pdma_engine.sv
`timescale 1ns/1ps
module pdma_engine
    import pdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              srst,
    input  logic              dir_in,
    input  desc_t             desc_a,
    input  desc_t             desc_b,
    input  logic [1:0]        ctx_valid,
    input  logic              desc_bad,
    output desc_t             cur_desc,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    output logic              dev_out_valid,
    output logic [BYTE_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [BYTE_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_tc,
    output logic              irq_a,
    output logic              irq_b,
    output logic              irq_err,
    output logic [1:0]        done_clr,
    output logic              cur_ctx,
    output logic              busy,
    output logic [LEN_W-1:0]  cnt
);
    eng_state_t        state, nxt;
    logic              run;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] byte_q;
    logic              last_q;
    logic              final_byte;

    assign run        = en && !srst;
    assign cur_desc   = cur_ctx ? desc_b : desc_a;
    assign final_byte = (cnt_q == LEN_W'(1));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (run && ctx_valid[cur_ctx]) nxt = ST_LOAD;
            ST_LOAD:  if (run) begin
                          if (desc_bad)                nxt = ST_FAULT;
                          else if (cur_desc.len == '0) nxt = ST_DONE;
                          else if (dir_in)             nxt = ST_CAPT;
                          else                         nxt = ST_FETCH;
                      end
            ST_FETCH: if (run && mem_gnt)       nxt = ST_PUSH;
            ST_PUSH:  if (run && dev_out_ready) nxt = final_byte ? ST_DONE : ST_FETCH;
            ST_CAPT:  if (run && dev_in_valid)  nxt = ST_STORE;
            ST_STORE: if (run && mem_gnt)       nxt = final_byte ? ST_DONE : ST_CAPT;
            ST_DONE:  nxt = ST_IDLE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= ST_IDLE;
        else if (srst)  state <= ST_IDLE;
        else            state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ctx <= 1'b0;
            addr_q  <= '0;
            cnt_q   <= '0;
            byte_q  <= '0;
            last_q  <= 1'b0;
        end else if (srst) begin
            cur_ctx <= 1'b0;
            cnt_q   <= '0;
        end else begin
            unique case (state)
                ST_LOAD: if (run && !desc_bad) begin
                    addr_q <= cur_desc.base;
                    cnt_q  <= cur_desc.len;
                    last_q <= cur_desc.last;
                end
                ST_FETCH: if (run && mem_gnt) byte_q <= mem_rdata;
                ST_PUSH: if (run && dev_out_ready) begin
                    addr_q <= addr_q + ADDR_W'(1);
                    cnt_q  <= cnt_q - LEN_W'(1);
                end
                ST_CAPT: if (run && dev_in_valid) byte_q <= dev_in_data;
                ST_STORE: if (run && mem_gnt) begin
                    addr_q <= addr_q + ADDR_W'(1);
                    cnt_q  <= cnt_q - LEN_W'(1);
                end
                ST_DONE, ST_FAULT: cur_ctx <= ~cur_ctx;
                default: ;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        dev_out_valid = 1'b0;
        dev_in_ready  = 1'b0;
        dev_tc        = 1'b0;
        irq_a         = 1'b0;
        irq_b         = 1'b0;
        irq_err       = 1'b0;
        done_clr      = 2'b00;
        unique case (state)
            ST_FETCH: mem_req = run;
            ST_STORE: begin
                mem_req = run;
                mem_we  = 1'b1;
            end
            ST_PUSH:  dev_out_valid = run;
            ST_CAPT:  dev_in_ready  = run;
            ST_DONE: begin
                dev_tc   = last_q && !srst;
                irq_a    = !cur_ctx && !srst;
                irq_b    = cur_ctx && !srst;
                done_clr = cur_ctx ? 2'b10 : 2'b01;
            end
            ST_FAULT: begin
                irq_err  = !srst;
                done_clr = cur_ctx ? 2'b10 : 2'b01;
            end
            default: ;
        endcase
    end

    assign mem_addr     = addr_q;
    assign mem_wdata    = byte_q;
    assign dev_out_data = byte_q;
    assign busy         = (state != ST_IDLE);
    assign cnt          = cnt_q;
endmodule

// File: rtl/pdma_pingpong.sv
`timescale 1ns/1ps
module pdma_pingpong
    import pdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    output logic              dev_out_valid,
    output logic [BYTE_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [BYTE_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_tc,
    output logic              irq_ctx_a,
    output logic              irq_ctx_b,
    output logic              irq_mem_err
);
    desc_t            desc_a, desc_b, cur_desc;
    logic             ctl_dir, ctl_en, ctl_srst;
    logic [1:0]       ctx_valid, done_clr;
    logic             cur_ctx, eng_busy, desc_bad;
    logic [LEN_W-1:0] eng_cnt;

    pdma_regs regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_ctx(cur_ctx),
        .done_clr(done_clr), .cnt(eng_cnt), .active(eng_busy && ctl_en),
        .desc_a(desc_a), .desc_b(desc_b), .ctl_dir(ctl_dir), .ctl_en(ctl_en),
        .ctl_srst(ctl_srst), .ctx_valid(ctx_valid)
    );

    pdma_desc_chk page_chk_i (
        .desc(cur_desc), .dir_in(ctl_dir), .bad(desc_bad)
    );

    pdma_engine eng_i (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .srst(ctl_srst), .dir_in(ctl_dir),
        .desc_a(desc_a), .desc_b(desc_b), .ctx_valid(ctx_valid), .desc_bad(desc_bad),
        .cur_desc(cur_desc), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready), .dev_tc(dev_tc),
        .irq_a(irq_ctx_a), .irq_b(irq_ctx_b), .irq_err(irq_mem_err),
        .done_clr(done_clr), .cur_ctx(cur_ctx), .busy(eng_busy), .cnt(eng_cnt)
    );
endmodule

// File: rtl/pdma_sva.sv
`timescale 1ns/1ps
module pdma_sva
    import pdma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_en,
    input logic              ctl_srst,
    input logic [1:0]        ctx_valid,
    input logic [LEN_W-1:0]  eng_cnt,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dev_out_valid,
    input logic              dev_in_ready,
    input logic              dev_tc,
    input logic              irq_ctx_a,
    input logic              irq_ctx_b,
    input logic              irq_mem_err
);
    // R8
    freeze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> (!mem_req && !dev_out_valid && !dev_in_ready));

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !ctl_srst) |=> ($stable(eng_cnt) && $stable(mem_addr)));

    // R9
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_srst |=> (eng_cnt == '0 && ctx_valid == 2'b00 &&
                      !irq_ctx_a && !irq_ctx_b && !irq_mem_err));

    // R4
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_ctx_a, irq_ctx_b, irq_mem_err}));

    // R5
    tc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tc |=> !dev_tc);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && ctl_en && !ctl_srst) |=>
        ((mem_req || !ctl_en || ctl_srst) && $stable(mem_addr)));
endmodule

bind pdma_pingpong pdma_sva sva_i (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_srst(ctl_srst),
    .ctx_valid(ctx_valid), .eng_cnt(eng_cnt), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .dev_out_valid(dev_out_valid), .dev_in_ready(dev_in_ready),
    .dev_tc(dev_tc), .irq_ctx_a(irq_ctx_a), .irq_ctx_b(irq_ctx_b),
    .irq_mem_err(irq_mem_err)
);

// File: tb/pdma_pingpong_tb_top.sv
`timescale 1ns/1ps
module pdma_pingpong_tb_top;
    import pdma_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_gnt = 1'b0;
    logic        dev_out_valid;
    logic [7:0]  dev_out_data;
    logic        dev_out_ready = 1'b0;
    logic        dev_in_valid = 1'b0;
    logic [7:0]  dev_in_data = '0;
    logic        dev_in_ready, dev_tc, irq_ctx_a, irq_ctx_b, irq_mem_err;

    always #2.5 clk = ~clk;

    pdma_pingpong dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_in_ready(dev_in_ready), .dev_tc(dev_tc), .irq_ctx_a(irq_ctx_a),
        .irq_ctx_b(irq_ctx_b), .irq_mem_err(irq_mem_err)
    );

    function automatic logic [7:0] mem_pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    assign mem_rdata = mem_pat(mem_addr);

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input int len, input bit last);
        return {last, 19'd0, 12'(len), base};
    endfunction
    function automatic logic [63:0] mk_ctl(input bit dir, input bit en, input bit rst, input bit vb, input bit va);
        return {59'd0, va, vb, rst, en, dir};
    endfunction

    int checks = 0, errors = 0;
    int out_total = 0, wr_total = 0, tc_cnt = 0, tc_at_bytes = -1;
    int irq_a_cnt = 0, irq_b_cnt = 0, err_cnt = 0;
    logic [7:0]  in_seq = 8'h30;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  exp_out_q[$];
    logic [39:0] exp_wr_q[$];
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // responders and scoreboard monitor
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_gnt       = lfsr[0] | lfsr[3];
        dev_out_ready = lfsr[1] | lfsr[5];
        dev_in_valid  = lfsr[2] | lfsr[6];
        dev_in_data   = in_seq;
        #1;
        if (rst_n) begin
            if (mem_req && mem_gnt && mem_we) begin
                wr_total++;
                if (exp_wr_q.size() == 0) chk("R3 unexpected memory write", {24'd0, mem_addr, mem_wdata}, 64'd0);
                else chk("R3 memory write addr/data", {24'd0, mem_addr, mem_wdata}, {24'd0, exp_wr_q.pop_front()});
            end
            if (dev_out_valid && dev_out_ready) begin
                out_total++;
                if (exp_out_q.size() == 0) chk("R2 unexpected device byte", {56'd0, dev_out_data}, 64'hFFFF);
                else chk("R2 device byte order", {56'd0, dev_out_data}, {56'd0, exp_out_q.pop_front()});
            end
            if (dev_in_valid && dev_in_ready) in_seq = in_seq + 8'd1;
            if (dev_tc) begin tc_cnt++; tc_at_bytes = out_total; end
            if (irq_ctx_a) irq_a_cnt++;
            if (irq_ctx_b) irq_b_cnt++;
            if (irq_mem_err) err_cnt++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1.2;
        d = reg_rdata;
    endtask

    task automatic push_out(input logic [31:0] base, input int len);
        for (int i = 0; i < len; i++) exp_out_q.push_back(mem_pat(base + 32'(i)));
    endtask

    task automatic push_in(input logic [31:0] base, input int len);
        for (int i = 0; i < len; i++) exp_wr_q.push_back({base + 32'(i), in_seq + 8'(i)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R4 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, d1, d2;
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(2'd2, v); chk("R1 ctrl after reset", v, 64'd0);
        rd(2'd3, v); chk("R1 diag after reset", v, 64'd0);
        rd(2'd0, v); chk("R1 ctx A after reset", v, 64'd0);
        chk("R1 idle outputs after reset", {60'd0, mem_req, dev_out_valid, dev_tc, irq_mem_err}, 64'd0);

        // ping-pong output, last flag on A only
        wr(2'd0, mk_desc(32'h100, 5, 1));
        wr(2'd1, mk_desc(32'h203, 3, 0));
        rd(2'd0, v); chk("R1 ctx A readback", v, mk_desc(32'h100, 5, 1));
        push_out(32'h100, 5); push_out(32'h203, 3);
        wr(2'd2, mk_ctl(0, 1, 0, 1, 1));
        wait (irq_b_cnt == 1);
        repeat (3) @(negedge clk);
        chk("R2 byte total A+B", 64'(out_total), 64'd8);
        chk("R4 irq A once", 64'(irq_a_cnt), 64'd1);
        chk("R5 tc pulses", 64'(tc_cnt), 64'd1);
        chk("R5 tc after A drained", 64'(tc_at_bytes), 64'd5);
        rd(2'd2, v); chk("R4 valid bits cleared", v, mk_ctl(0, 1, 0, 0, 0));
        rd(2'd3, v); chk("R4 idle on context A", v, 64'd0);

        // freeze, ignored writes, valid write-1-set
        wr(2'd0, mk_desc(32'h400, 40, 0));
        push_out(32'h400, 40);
        wr(2'd2, mk_ctl(0, 1, 0, 0, 1));
        wait (out_total >= 18);
        wr(2'd2, mk_ctl(0, 0, 0, 0, 0));
        repeat (4) @(negedge clk);
        snap = out_total;
        rd(2'd3, d1);
        repeat (20) @(negedge clk);
        rd(2'd3, d2);
        chk("R8 no bytes while frozen", 64'(out_total), 64'(snap));
        chk("R8 diag stable while frozen", d2, d1);
        chk("R8 frozen diag count/active/ctx", d1, {50'd0, 12'(40 - (snap - 8)), 1'b0, 1'b0});
        wr(2'd0, mk_desc(32'h900, 2, 1));
        rd(2'd0, v); chk("R10 write to busy ctx A ignored", v, mk_desc(32'h400, 40, 0));
        wr(2'd1, mk_desc(32'h500, 2, 0));
        rd(2'd1, v); chk("R10 write to idle ctx B taken", v, mk_desc(32'h500, 2, 0));
        rd(2'd2, v); chk("R12 zero write keeps valid A", v, mk_ctl(0, 0, 0, 0, 1));
        wr(2'd2, mk_ctl(0, 1, 0, 0, 0));
        wait (irq_a_cnt == 2);
        repeat (3) @(negedge clk);
        chk("R8 resumed total", 64'(out_total), 64'd48);
        chk("R5 no tc when last=0", 64'(tc_cnt), 64'd1);
        rd(2'd3, v); chk("R4 idle on invalid B", v, 64'd1);

        // device to memory on context B
        wr(2'd1, mk_desc(32'h840, 6, 1));
        push_in(32'h840, 6);
        wr(2'd2, mk_ctl(1, 1, 0, 1, 0));
        wait (irq_b_cnt == 2);
        repeat (3) @(negedge clk);
        chk("R3 write total", 64'(wr_total), 64'd6);
        chk("R5 tc after input buffer", 64'(tc_cnt), 64'd2);

        // unaligned input base on A
        wr(2'd0, mk_desc(32'h841, 4, 0));
        wr(2'd2, mk_ctl(1, 1, 0, 0, 1));
        wait (err_cnt == 1);
        repeat (3) @(negedge clk);
        chk("R7 no write on misaligned input", 64'(wr_total), 64'd6);
        chk("R7 no completion irq", 64'(irq_a_cnt), 64'd2);
        rd(2'd2, v); chk("R7 valid A cleared", v, mk_ctl(1, 1, 0, 0, 0));
        rd(2'd3, v); chk("R7 switched to B", v, 64'd1);
        wr(2'd1, mk_desc(32'h841, 3, 0));
        push_out(32'h841, 3);
        wr(2'd2, mk_ctl(0, 1, 0, 1, 0));
        wait (irq_b_cnt == 3);
        repeat (3) @(negedge clk);
        chk("R7 unaligned output accepted", 64'(err_cnt), 64'd1);
        chk("R7 unaligned output bytes", 64'(out_total), 64'd51);

        // page crossing on A, exact boundary on B
        wr(2'd0, mk_desc(32'hFFE, 4, 0));
        wr(2'd2, mk_ctl(0, 1, 0, 0, 1));
        wait (err_cnt == 2);
        repeat (3) @(negedge clk);
        chk("R6 no bytes on page cross", 64'(out_total), 64'd51);
        wr(2'd1, mk_desc(32'h1FFC, 4, 1));
        push_out(32'h1FFC, 4);
        wr(2'd2, mk_ctl(0, 1, 0, 1, 0));
        wait (irq_b_cnt == 4);
        repeat (3) @(negedge clk);
        chk("R6 boundary end allowed", 64'(out_total), 64'd55);
        chk("R6 no extra error", 64'(err_cnt), 64'd2);

        // zero length on A
        wr(2'd0, mk_desc(32'h300, 0, 1));
        wr(2'd2, mk_ctl(0, 1, 0, 0, 1));
        wait (irq_a_cnt == 3);
        repeat (3) @(negedge clk);
        chk("R11 zero length tc", 64'(tc_cnt), 64'd4);
        chk("R11 zero length no bytes", 64'(out_total), 64'd55);

        // soft reset mid-transfer on B
        wr(2'd1, mk_desc(32'h600, 30, 0));
        push_out(32'h600, 30);
        wr(2'd2, mk_ctl(0, 1, 0, 1, 0));
        wait (out_total >= 60);
        wr(2'd2, mk_ctl(0, 1, 1, 0, 0));
        repeat (3) @(negedge clk);
        exp_out_q.delete();
        rd(2'd3, v); chk("R9 diag cleared", v, 64'd0);
        rd(2'd2, v); chk("R9 valid cleared", v, mk_ctl(0, 1, 1, 0, 0));
        rd(2'd1, v); chk("R9 ctx B kept", v, mk_desc(32'h600, 30, 0));
        chk("R9 no irq", 64'(irq_b_cnt), 64'd4);
        wr(2'd2, mk_ctl(0, 1, 0, 0, 0));
        wr(2'd0, mk_desc(32'h700, 2, 0));
        push_out(32'h700, 2);
        wr(2'd2, mk_ctl(0, 1, 0, 0, 1));
        wait (irq_a_cnt == 4);
        repeat (3) @(negedge clk);
        chk("R4 restart on A after reset", 64'(irq_b_cnt), 64'd4);
        chk("R2 queue drained", 64'(exp_out_q.size()), 64'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule